// File: doc/BRIEF.md
# Byte-Lane Write Datapath with Sleep Gating

This block is the storage side of a flow-through synchronous burst memory. A burst controller in front of it supplies the word address for every cycle. It also supplies a select flag for cycles that access the array and a strobe flag for the first cycle of a burst, when a new address is loaded. The block decodes the write controls into per-lane write strobes and updates only the enabled byte lanes. On a read it presents the addressed word on the outputs in the cycle that follows the registering clock edge, with no further pipeline stage.

Three controls take priority in turn. A global write enable writes every lane. Below it, a byte-write gate hands the choice of lanes to the per-lane enables. In every other case the cycle is a read. An asynchronous output enable and an asynchronous sleep input both release the output drive at once. Sleep also blocks array accesses and keeps the stored contents. When sleep is released there is a recovery window of two clock edges. A strobe that arrives in that window is dropped and flagged.

Top module: `bwd_datapath`

## Requirements
- R1: With `gw_n_i` low on an accepted access, all lanes are written from `wdata_i`, whatever `bw_n_i` and `lane_we_n_i` are.
- R2: With `gw_n_i` high and `bw_n_i` low, exactly the lanes whose `lane_we_n_i` bit is low are written, and every other lane keeps its old value.
- R3: With `gw_n_i` high and either `bw_n_i` high or all `lane_we_n_i` bits high, the access is a read and no lane changes.
- R4: Lane k occupies bits [9k+8:9k] of `wdata_i` and `rdata_o`, lane 0 being the lowest. Bit 9k+8 is that lane's parity bit and is written together with its eight data bits.
- R5: After a rising edge that accepts a read at address A, `rdata_o` carries the word stored at A and `rdata_oe_o` is high in that same cycle, provided `oe_n_i` and `sleep_i` are low. A write at one edge is visible to a read at the next.
- R6: `rdata_oe_o` is low, and `rdata_o` is zero, immediately while `oe_n_i` is high, and in the cycle after a write edge or a deselected edge (`sel_i` low).
- R7: While `sleep_i` is high, `rdata_oe_o` goes low at once and an access at any edge is ignored. Stored words are unchanged when sleep ends.
- R8: At the first two rising edges after `sleep_i` falls, an access is ignored. If `strb_i` and `sel_i` were high there, `strb_drop_o` is high for the following cycle. An access at the third edge is accepted.
- R9: `pdown_o` rises after the second rising edge that samples `sleep_i` high, and falls after the second edge that samples it low.
- R10: During and just after reset, `rdata_oe_o`, `strb_drop_o` and `pdown_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access cycle with the device selected |
| strb_i | input | 1 | First cycle of a burst (new address) |
| addr_i | input | AW | Word address from the burst controller |
| gw_n_i | input | 1 | Global write enable, active low |
| bw_n_i | input | 1 | Byte-write gate, active low |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| wdata_i | input | 9*LANES | Write data, 9 bits per lane |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| rdata_o | output | 9*LANES | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Output drive enable (low stands for high-Z) |
| strb_drop_o | output | 1 | A strobe was dropped at the last edge |
| pdown_o | output | 1 | Power-down state reached |

## Verification
The hardest state to reach is an access that lands in the recovery window just after sleep falls. In that window the inputs look normal, yet the edge must be ignored. The stimulus parks a write to an address it has already checked, raises sleep for several cycles and then lowers it. It then offers strobed writes on both window edges and a read on the third. The read must return the old word and the flag must be seen twice. A random phase then mixes short sleep pulses, output-enable toggles and byte masks against a behavioural model.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int LANE_BITS = 9;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bwd_decode.sv
module bwd_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n_i,
  input  logic             bw_n_i,
  input  logic [LANES-1:0] lane_we_n_i,
  output logic [LANES-1:0] lane_wr_o,
  output logic             is_wr_o
);
  // global write overrides the byte gate and lane enables
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr_o[g] = ~gw_n_i | (~bw_n_i & ~lane_we_n_i[g]);
  end

  assign is_wr_o = |lane_wr_o;
endmodule

// File: rtl/bwd_sleep_gate.sv
module bwd_sleep_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic block_o,
  output logic pdown_o
);
  logic [1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 2'b00;
    else         hist_q <= {hist_q[0], sleep_i};
  end

  // blocked while asleep and for two edges after release
  assign block_o = sleep_i | hist_q[0] | hist_q[1];
  assign pdown_o = hist_q[1];

  a_r8_wake_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |-> block_o);
  a_r8_wake_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |=> block_o);
  a_r9_pd_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdown_o) |-> $past(sleep_i, 2));
endmodule

// File: rtl/bwd_lane_array.sv
module bwd_lane_array #(
  parameter int LANES = 4,
  parameter int AW    = 6
) (
  input  logic                             clk_i,
  input  logic [LANES-1:0]                 we_i,
  input  logic [AW-1:0]                    waddr_i,
  input  logic [LANES*bwd_pkg::LANE_BITS-1:0] wdata_i,
  input  logic [AW-1:0]                    raddr_i,
  output logic [LANES*bwd_pkg::LANE_BITS-1:0] rdata_o
);
  localparam int LB    = bwd_pkg::LANE_BITS;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LB-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[waddr_i] <= wdata_i[g*LB +: LB];
    end

    assign rdata_o[g*LB +: LB] = mem_q[raddr_i];
  end
endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath
  import bwd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic                       strb_i,
  input  logic [AW-1:0]              addr_i,
  input  logic                       gw_n_i,
  input  logic                       bw_n_i,
  input  logic [LANES-1:0]           lane_we_n_i,
  input  logic [LANES*LANE_BITS-1:0] wdata_i,
  input  logic                       oe_n_i,
  input  logic                       sleep_i,
  output logic [LANES*LANE_BITS-1:0] rdata_o,
  output logic                       rdata_oe_o,
  output logic                       strb_drop_o,
  output logic                       pdown_o
);
  localparam int W = LANES * LANE_BITS;

  logic [LANES-1:0] lane_wr;
  logic             is_wr;
  logic             block;
  logic             acc;
  logic             wr_fire;
  logic [LANES-1:0] arr_we;
  logic [W-1:0]     arr_rd;
  op_e              op_q;
  logic [AW-1:0]    addr_q;
  logic             drop_q;

  bwd_decode #(.LANES(LANES)) u_dec (
    .gw_n_i      (gw_n_i),
    .bw_n_i      (bw_n_i),
    .lane_we_n_i (lane_we_n_i),
    .lane_wr_o   (lane_wr),
    .is_wr_o     (is_wr)
  );

  bwd_sleep_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sleep_i (sleep_i),
    .block_o (block),
    .pdown_o (pdown_o)
  );

  assign acc     = sel_i & ~block;
  assign wr_fire = acc & is_wr;
  assign arr_we  = lane_wr & {LANES{wr_fire}};

  bwd_lane_array #(.LANES(LANES), .AW(AW)) u_arr (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .waddr_i (addr_i),
    .wdata_i (wdata_i),
    .raddr_i (addr_q),
    .rdata_o (arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      drop_q <= 1'b0;
    end else begin
      if (!acc)       op_q <= OP_NONE;
      else if (is_wr) op_q <= OP_WRITE;
      else            op_q <= OP_READ;
      addr_q <= addr_i;
      drop_q <= sel_i & strb_i & block;
    end
  end

  // flow-through: array word follows the registered address directly
  assign rdata_oe_o  = (op_q == OP_READ) & ~oe_n_i & ~sleep_i;
  assign rdata_o     = rdata_oe_o ? arr_rd : '0;
  assign strb_drop_o = drop_q;

  a_r1_gw_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gw_n_i |-> (lane_wr == '1));
  a_r3_read_no_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_n_i && (bw_n_i || (&lane_we_n_i))) |-> (lane_wr == '0));
  a_r6_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !rdata_oe_o);
  a_r8_drop_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && strb_i && block) |=> strb_drop_o);
  a_r7_no_write_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (arr_we == '0));
endmodule

// File: tb/sim_bwd_datapath.sv
module sim_bwd_datapath;
  localparam int CLK_P = 10;
  localparam int LANES = 4;
  localparam int AW    = 6;
  localparam int W     = LANES * 9;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             sel, strb, gw_n, bw_n, oe_n, sleep;
  logic [AW-1:0]    addr;
  logic [LANES-1:0] we_n;
  logic [W-1:0]     wdata;
  logic [W-1:0]     rdata_o;
  logic             rdata_oe_o, strb_drop_o, pdown_o;

  always #(CLK_P/2) clk = ~clk;

  bwd_datapath #(.LANES(LANES), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .strb_i(strb), .addr_i(addr),
    .gw_n_i(gw_n), .bw_n_i(bw_n), .lane_we_n_i(we_n), .wdata_i(wdata),
    .oe_n_i(oe_n), .sleep_i(sleep), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
    .strb_drop_o(strb_drop_o), .pdown_o(pdown_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R10";

  // behavioural reference
  logic [W-1:0] ref_mem [DEPTH];
  bit           h1, h2, rd_m, drop_m, pd_m;
  int           addr_m;

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit           oe_e;
    logic [W-1:0] dq_e;
    oe_e = rd_m && !oe_n && !sleep;
    dq_e = oe_e ? ref_mem[addr_m] : '0;
    chk("rdata_oe", W'(rdata_oe_o), W'(oe_e));
    chk("rdata",    rdata_o,        dq_e);
    chk("strb_drop", W'(strb_drop_o), W'(drop_m));
    chk("pdown",    W'(pdown_o),    W'(pd_m));
  endtask

  task automatic model_edge();
    bit               blk;
    bit               ok;
    logic [LANES-1:0] mask;
    blk = sleep || h1 || h2;
    ok  = sel && !blk;
    if (!gw_n)      mask = '1;
    else if (!bw_n) mask = ~we_n;
    else            mask = '0;
    if (ok && mask != 0) begin
      for (int k = 0; k < LANES; k++)
        if (mask[k]) ref_mem[addr][k*9 +: 9] = wdata[k*9 +: 9];
    end
    rd_m   = ok && (mask == 0);
    addr_m = addr;
    drop_m = sel && strb && blk;
    pd_m   = h1;
    h2     = h1;
    h1     = sleep;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_ni) model_edge();
    else begin h1 = 0; h2 = 0; rd_m = 0; drop_m = 0; pd_m = 0; end
    #1;
    compare_all();
  endtask

  task automatic go(bit s, bit st, int a, bit g, bit b, logic [LANES-1:0] w,
                    logic [W-1:0] d);
    sel = s; strb = st; addr = AW'(a); gw_n = g; bw_n = b; we_n = w; wdata = d;
    tick();
  endtask

  function automatic logic [W-1:0] pat(int a);
    return {4{9'(a * 37 + 5)}} ^ 36'h5_A5C3_96F1;
  endfunction

  initial begin
    rst_ni = 1'b0; sel = 0; strb = 0; addr = '0; gw_n = 1; bw_n = 1;
    we_n = '1; wdata = '0; oe_n = 0; sleep = 0;
    h1 = 0; h2 = 0; rd_m = 0; drop_m = 0; pd_m = 0; addr_m = 0;
    cur_req = "R10";
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    cur_req = "R1";
    for (int a = 0; a < DEPTH; a++) go(1, 1, a, 0, 1, '1, pat(a));

    cur_req = "R5";
    for (int a = 0; a < 8; a++) go(1, 1, a * 7 % DEPTH, 1, 1, '0, '0);
    go(1, 1, 9, 0, 1, '1, 36'h1_2345_6789);
    go(1, 1, 9, 1, 1, '1, '0);

    cur_req = "R2";
    go(1, 1, 10, 1, 0, 4'b1010, 36'hF_FFFF_FFFF);
    go(1, 1, 10, 1, 1, '1, '0);
    go(1, 0, 11, 1, 0, 4'b0111, 36'hA_BCDE_F012);
    go(1, 0, 11, 1, 1, '1, '0);
    cur_req = "R4";
    go(1, 1, 12, 1, 0, 4'b1110, 36'h0_0000_01FF);
    go(1, 1, 12, 1, 1, '1, '0);
    go(1, 1, 13, 1, 0, 4'b0111, 36'hF_F800_0000);
    go(1, 1, 13, 1, 1, '1, '0);

    cur_req = "R3";
    go(1, 1, 14, 1, 1, 4'b0000, 36'h0_0000_0000);
    go(1, 1, 15, 1, 0, 4'b1111, 36'h0_0000_0000);
    go(1, 1, 14, 1, 1, '1, '0);
    go(1, 1, 15, 1, 1, '1, '0);

    cur_req = "R1";
    go(1, 1, 16, 0, 0, 4'b1110, 36'h3_3333_3333);
    go(1, 1, 16, 1, 1, '1, '0);

    cur_req = "R6";
    go(1, 1, 20, 1, 1, '1, '0);
    oe_n = 1; #1 compare_all();
    oe_n = 0; #1 compare_all();
    go(1, 1, 21, 0, 1, '1, pat(99));
    go(0, 0, 21, 1, 1, '1, '0);
    go(1, 0, 21, 1, 1, '1, '0);

    cur_req = "R7";
    go(1, 1, 30, 1, 1, '1, '0);
    sleep = 1; #1 compare_all();
    go(1, 1, 30, 0, 1, '1, 36'h0_DEAD_BEEF);
    cur_req = "R9";
    go(1, 1, 31, 0, 1, '1, 36'h0_DEAD_BEEF);
    go(0, 0, 31, 1, 1, '1, '0);
    go(0, 0, 31, 1, 1, '1, '0);
    sleep = 0;
    cur_req = "R8";
    go(1, 1, 30, 0, 1, '1, 36'h0_0BAD_F00D);
    go(1, 1, 31, 0, 1, '1, 36'h0_0BAD_F00D);
    go(1, 1, 30, 1, 1, '1, '0);
    go(1, 1, 31, 1, 1, '1, '0);
    go(1, 1, 32, 0, 1, '1, 36'h7_7777_7777);
    go(1, 1, 32, 1, 1, '1, '0);

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) sleep = ~sleep;
      oe_n = (r[7:4] == 0);
      go(r[8] | r[9], r[10], int'(r[16:11]), r[17] | r[18], r[19],
         LANES'(r[23:20]), {$urandom, 4'(r[27:24])});
    end
    sleep = 0;
    repeat (3) go(0, 0, 0, 1, 1, '1, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog %s act=running exp=done", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule